// File: doc/BRIEF.md
# Register-Driven Serial Flash Shift Engine

This block lets a processor talk to serial NAND flash one register write at a time. The processor selects a device through an active-low chip-select register and sets the byte count and lane width of the next outgoing burst in a command word. Writing a 32-bit data word then clocks up to four bytes out, most significant byte first. Writing a read command instead clocks up to four bytes in and leaves them, left-aligned, in a read-data register.

Chip-select is independent of the transfers. Software asserts it once, issues the opcode, address, dummy and data bursts as separate register writes, and polls the busy flag between them. When software is done, it releases chip-select. The serial clock idles low and runs only while a burst is in flight. Data changes on the falling edge and is sampled on the rising edge. One, two or four data lines carry each burst.

Top module: `snand_shift_engine`

## Requirements
- R1: Register offsets (byte addresses): chip-select 0x04, write command 0x08, read command 0x0C, read data 0x10, write data 0x14, status 0x40. Any other address reads zero, and writes to it do nothing.
- R2: A command word carries the byte count minus one in bits 1:0 and a width code in bits 29:28. Code 0 means one line, code 1 two lines, code 2 four lines, and code 3 also gives four lines. The write command register reads back as the stored count and width code, with all other bits zero.
- R3: Writing the write-data register while idle sends (count+1) bytes from bits 31:24 downward, most significant bit first. On one line the bit goes out on io[0]. On two lines the pair goes out on io[1:0], with io[1] carrying the higher bit. On four lines the nibble goes out on io[3:0], with io[3] carrying the highest bit.
- R4: Status bit 3 is 1 while a burst is in flight. Bit 2 is 1 while a read burst is in flight, and bit 1 is 1 while a write burst is in flight. All other status bits read 0.
- R5: Chip-select bit 4*i of the chip-select register drives cs_n[i] directly (active low) for two devices. The register reads back as all ones except those bits. It holds its value across any number of bursts until it is written again.
- R6: Writing the read-command register while idle clocks in (count+1) bytes at the given width. Single-line reads sample io[1]. After busy clears, the read-data register holds the bytes packed from bits 31:24, first bit received in the highest position, with unused low bytes zero.
- R7: The serial clock idles low. During a burst it toggles every CLK_HALF system clocks, starting low. A burst of N serial clocks holds busy for exactly 2*N*CLK_HALF system clocks, and busy and the clock fall together on the last edge.
- R8: During a write burst, only the lanes of the selected width have output enable set. During a read burst, and while idle, every output enable is 0, and every line not driven outputs 0.
- R9: A write to the write-data or read-command register while busy is ignored: the burst in flight continues unchanged and no new burst follows.
- R10: After reset the engine is idle, both devices are deselected, status reads 0 and read data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low device selects |
| spi_io_out | output | 4 | Serial data out per lane |
| spi_io_oe | output | 4 | Output enable per lane |
| spi_io_in | input | 4 | Serial data in per lane |

## Verification
The bench builds the engine with CLK_HALF set to 3. It keeps the default of two devices and eight address bits. An odd half period of three system clocks makes it possible to detect a rising edge that is off by one cycle, or a shift that uses the wrong phase. A divide-by-two setting would hide both. At this setting the longest burst, four bytes on one line, takes 192 system clocks. Every lane width and byte count fits in the run, including bursts that arrive while busy and must be ignored.

// File: rtl/snand_pkg.sv
package snand_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CSEL = 8'h04;
  localparam logic [7:0] OFS_WCMD = 8'h08;
  localparam logic [7:0] OFS_RCMD = 8'h0C;
  localparam logic [7:0] OFS_RDAT = 8'h10;
  localparam logic [7:0] OFS_WDAT = 8'h14;
  localparam logic [7:0] OFS_STAT = 8'h40;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    lane_e      lanes;
    logic [1:0] cnt_m1;
  } xfer_cmd_t;

  function automatic xfer_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    xfer_cmd_t c;
    case (w[29:28])
      2'd0:    c.lanes = LANE_X1;
      2'd1:    c.lanes = LANE_X2;
      default: c.lanes = LANE_X4;
    endcase
    c.cnt_m1 = w[1:0];
    return c;
  endfunction

  // serial clock periods needed for one burst
  function automatic logic [5:0] sclk_cycles(input xfer_cmd_t c);
    logic [5:0] bits;
    bits = {({1'b0, c.cnt_m1} + 3'd1), 3'b000};
    case (c.lanes)
      LANE_X1: return bits;
      LANE_X2: return bits >> 1;
      default: return bits >> 2;
    endcase
  endfunction

endpackage

// File: rtl/snand_regfile.sv
module snand_regfile
  import snand_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                rd_active,
  input  logic                wr_active,
  input  logic [WORD_W-1:0]   rx_word,
  output logic [NUM_CS-1:0]   cs_n,
  output logic                start_wr,
  output logic                start_rd,
  output xfer_cmd_t           start_cmd,
  output logic [WORD_W-1:0]   start_data
);

  logic wr_csel, wr_wcmd, wr_rcmd, wr_wdat;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              cs_en;
  xfer_cmd_t         wcmd_q, wcmd_d;
  logic              wcmd_en;
  logic [WORD_W-1:0] csel_rb;

  always_comb begin
    wr_csel = bus_wr && (bus_addr == ADDR_W'(OFS_CSEL));
    wr_wcmd = bus_wr && (bus_addr == ADDR_W'(OFS_WCMD));
    wr_rcmd = bus_wr && (bus_addr == ADDR_W'(OFS_RCMD));
    wr_wdat = bus_wr && (bus_addr == ADDR_W'(OFS_WDAT));
  end

  assign cs_en   = wr_csel;
  assign wcmd_en = wr_wcmd;

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_d[i] = bus_wdata[4*i];
    end
  endgenerate

  assign wcmd_d = decode_cmd(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      wcmd_q <= '{lanes: LANE_X1, cnt_m1: 2'd0};
    end else begin
      if (cs_en)   cs_q   <= cs_d;
      if (wcmd_en) wcmd_q <= wcmd_d;
    end
  end

  assign cs_n = cs_q;

  always_comb begin
    start_wr   = wr_wdat && !busy;
    start_rd   = wr_rcmd && !busy;
    start_cmd  = start_rd ? decode_cmd(bus_wdata) : wcmd_q;
    start_data = bus_wdata;
  end

  always_comb begin
    csel_rb = '1;
    for (int i = 0; i < NUM_CS; i++) csel_rb[4*i] = cs_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CSEL))      bus_rdata = csel_rb;
    else if (bus_addr == ADDR_W'(OFS_WCMD)) bus_rdata = {2'b00, wcmd_q.lanes, 26'd0, wcmd_q.cnt_m1};
    else if (bus_addr == ADDR_W'(OFS_RDAT)) bus_rdata = rx_word;
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = {28'd0, busy, rd_active, wr_active, 1'b0};
  end

  // chip-select only moves on a write to its register
  assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_csel |=> $stable(cs_n));

endmodule

// File: rtl/snand_sclk_gen.sv
module snand_sclk_gen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic sclk,
  output logic rise_tk,
  output logic fall_tk
);

  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] div_q, div_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run && (div_q == CW'(CLK_HALF - 1));

  always_comb begin
    div_d  = '0;
    sclk_d = 1'b0;
    if (!restart && run) begin
      div_d  = tick ? '0 : div_q + 1'b1;
      sclk_d = tick ? ~sclk_q : sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk    = sclk_q;
  assign rise_tk = tick && !sclk_q;
  assign fall_tk = tick &&  sclk_q;

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sclk_q);

endmodule

// File: rtl/snand_shifter.sv
module snand_shifter
  import snand_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  xfer_cmd_t         cmd,
  input  logic [WORD_W-1:0] data,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic [3:0]        io_in,
  output logic              busy,
  output logic              rd_active,
  output logic              wr_active,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic [WORD_W-1:0] rx_word
);

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  lane_e             lanes_q, lanes_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [5:0]        left_q, left_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] rxw_q, rxw_d;
  logic              start;
  logic [4:0]        align_sh;
  logic [3:0]        lane_mask, lane_val;

  assign start    = start_wr || start_rd;
  assign align_sh = {~cnt_q, 3'b000};

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    lanes_d = lanes_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    rxw_d   = rxw_q;
    if (start) begin
      busy_d  = 1'b1;
      rd_d    = start_rd;
      lanes_d = cmd.lanes;
      cnt_d   = cmd.cnt_m1;
      left_d  = sclk_cycles(cmd);
      sh_d    = start_rd ? '0 : data;
      rx_d    = '0;
    end else if (busy_q) begin
      if (rise_tk && rd_q) begin
        case (lanes_q)
          LANE_X1: rx_d = {rx_q[WORD_W-2:0], io_in[1]};
          LANE_X2: rx_d = {rx_q[WORD_W-3:0], io_in[1:0]};
          default: rx_d = {rx_q[WORD_W-5:0], io_in};
        endcase
      end
      if (fall_tk) begin
        case (lanes_q)
          LANE_X1: sh_d = {sh_q[WORD_W-2:0], 1'b0};
          LANE_X2: sh_d = {sh_q[WORD_W-3:0], 2'b00};
          default: sh_d = {sh_q[WORD_W-5:0], 4'b0000};
        endcase
        left_d = left_q - 6'd1;
        if (left_q == 6'd1) begin
          busy_d = 1'b0;
          if (rd_q) rxw_d = rx_q << align_sh;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      lanes_q <= LANE_X1;
      cnt_q   <= 2'd0;
      left_q  <= 6'd0;
      sh_q    <= '0;
      rx_q    <= '0;
      rxw_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      lanes_q <= lanes_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      sh_q    <= sh_d;
      rx_q    <= rx_d;
      rxw_q   <= rxw_d;
    end
  end

  always_comb begin
    case (lanes_q)
      LANE_X1: begin lane_mask = 4'b0001; lane_val = {3'b000, sh_q[WORD_W-1]}; end
      LANE_X2: begin lane_mask = 4'b0011; lane_val = {2'b00, sh_q[WORD_W-1:WORD_W-2]}; end
      default: begin lane_mask = 4'b1111; lane_val = sh_q[WORD_W-1:WORD_W-4]; end
    endcase
  end

  assign io_oe     = (busy_q && !rd_q) ? lane_mask : 4'b0000;
  assign io_out    = (busy_q && !rd_q) ? lane_val  : 4'b0000;
  assign busy      = busy_q;
  assign rd_active = busy_q &&  rd_q;
  assign wr_active = busy_q && !rd_q;
  assign rx_word   = rxw_q;

  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q) |-> (io_oe == 4'b0000));

  assert_lane_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  assert_busy_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_tk) |=> (busy_q && $stable(rd_q) && $stable(lanes_q) && $stable(cnt_q)));

  assert_no_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!rise_tk && !fall_tk));

endmodule

// File: rtl/snand_shift_engine.sv
module snand_shift_engine
  import snand_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int NUM_CS   = 2,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              busy, rd_active, wr_active;
  logic [WORD_W-1:0] rx_word, start_data;
  logic              start_wr, start_rd;
  xfer_cmd_t         start_cmd;
  logic              rise_tk, fall_tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  snand_regfile #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .rd_active  (rd_active),
    .wr_active  (wr_active),
    .rx_word    (rx_word),
    .cs_n       (spi_cs_n),
    .start_wr   (start_wr),
    .start_rd   (start_rd),
    .start_cmd  (start_cmd),
    .start_data (start_data)
  );

  snand_sclk_gen #(.CLK_HALF(CLK_HALF)) u_sclk (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .run     (busy),
    .restart (start_wr || start_rd),
    .sclk    (spi_sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  snand_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .cmd       (start_cmd),
    .data      (start_data),
    .rise_tk   (rise_tk),
    .fall_tk   (fall_tk),
    .io_in     (spi_io_in),
    .busy      (busy),
    .rd_active (rd_active),
    .wr_active (wr_active),
    .io_out    (spi_io_out),
    .io_oe     (spi_io_oe),
    .rx_word   (rx_word)
  );

endmodule

// File: tb/sim_snand_shift_engine.sv
`timescale 1ns/1ps
module sim_snand_shift_engine;

  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        spi_sclk;
  logic [1:0]  spi_cs_n;
  logic [3:0]  spi_io_out, spi_io_oe;
  logic [3:0]  spi_io_in = 4'h0;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  snand_shift_engine #(.CLK_HALF(D), .NUM_CS(2), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(spi_io_in)
  );

  // behavioural reference state
  int          m_left = 0;
  int          m_n = 0;
  int          m_L = 1;
  int          m_bytes = 1;
  bit          m_rd = 1'b0;
  logic [31:0] m_data = 32'h0;
  logic [63:0] m_rx = 64'h0;
  logic [31:0] m_rdword = 32'h0;
  logic [1:0]  m_cs = 2'b11;
  int          m_wbytes = 1;
  int          m_wL = 1;

  function automatic int lanes_of(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_rd = 1'b0; m_rdword = 32'h0; m_cs = 2'b11;
      m_wbytes = 1; m_wL = 1; m_data = 32'h0; m_rx = 64'h0;
    end else begin
      bit was_busy;
      was_busy = (m_left > 0);
      if (was_busy) begin
        int e_after;
        e_after = 2*m_n*D - m_left + 1;
        if (m_rd && (e_after % (2*D)) == D) begin
          if (m_L == 1)      m_rx = (m_rx << 1) | 64'(spi_io_in[1]);
          else if (m_L == 2) m_rx = (m_rx << 2) | 64'(spi_io_in[1:0]);
          else               m_rx = (m_rx << 4) | 64'(spi_io_in);
        end
        m_left = m_left - 1;
        if (m_left == 0 && m_rd) m_rdword = 32'(m_rx << (32 - 8*m_bytes));
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h04: m_cs = {bus_wdata[4], bus_wdata[0]};
          8'h08: begin m_wbytes = int'(bus_wdata[1:0]) + 1; m_wL = lanes_of(bus_wdata[29:28]); end
          8'h14: if (!was_busy) begin
            m_rd = 1'b0; m_bytes = m_wbytes; m_L = m_wL; m_data = bus_wdata;
            m_n = m_bytes*8/m_L; m_left = 2*m_n*D;
          end
          8'h0C: if (!was_busy) begin
            m_rd = 1'b1; m_bytes = int'(bus_wdata[1:0]) + 1; m_L = lanes_of(bus_wdata[29:28]);
            m_data = 32'h0; m_rx = 64'h0; m_n = m_bytes*8/m_L; m_left = 2*m_n*D;
          end
          default: ;
        endcase
      end
    end
  end

  // lane stimulus: changes only at the falling system clock edge
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    spi_io_in <= lfsr[3:0];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison of the serial pins
  always @(negedge clk) begin
    if (cmp_on) begin
      logic       e_sclk;
      logic [3:0] e_oe, e_out;
      logic [31:0] sh;
      int e;
      e_sclk = 1'b0; e_oe = 4'h0; e_out = 4'h0;
      if (m_left > 0) begin
        e = 2*m_n*D - m_left;
        e_sclk = ((e / D) % 2) == 1;
        if (!m_rd) begin
          sh = m_data << ((e / (2*D)) * m_L);
          if (m_L == 1)      begin e_oe = 4'b0001; e_out = {3'b000, sh[31]}; end
          else if (m_L == 2) begin e_oe = 4'b0011; e_out = {2'b00, sh[31:30]}; end
          else               begin e_oe = 4'b1111; e_out = sh[31:28]; end
        end
      end
      check("R7 sclk", {31'd0, spi_sclk}, {31'd0, e_sclk});
      check("R8 oe", {28'd0, spi_io_oe}, {28'd0, e_oe});
      check("R3 io_out", {28'd0, spi_io_out}, {28'd0, e_out});
      check("R5 cs_n", {30'd0, spi_cs_n}, {30'd0, m_cs});
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_status();
    bit b;
    b = (m_left > 0);
    return {28'd0, b, b && m_rd, b && !m_rd, 1'b0};
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      bus_read(8'h40, s);
      check("R4 status", s, exp_status());
      if (s[3] == 1'b0) break;
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_test();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;

    // R10 reset state
    bus_read(8'h40, r); check("R10 status after reset", r, 32'h0);
    bus_read(8'h04, r); check("R10 cs readback after reset", r, 32'hFFFF_FFFF);
    bus_read(8'h10, r); check("R10 read data after reset", r, 32'h0);
    bus_read(8'h20, r); check("R1 unmapped reads zero", r, 32'h0);

    // R5 select device 0
    bus_write(8'h04, 32'hFFFF_FFFE);
    bus_read(8'h04, r); check("R5 cs readback dev0", r, 32'hFFFF_FFFE);

    // R3 single line, four bytes
    bus_write(8'h08, 32'h0000_0003);
    bus_read(8'h08, r); check("R2 wcmd readback", r, 32'h0000_0003);
    bus_write(8'h14, 32'h9FA5_3C01);
    bus_read(8'h40, r); check("R4 status while writing", r, 32'h0000_000A);
    wait_idle();

    // R3 two lines, two bytes
    bus_write(8'h08, 32'h1000_0001);
    bus_write(8'h14, 32'hC35A_7777);
    wait_idle();

    // R3 four lines, three bytes; R2 readback of width code
    bus_write(8'h08, 32'h2000_0002);
    bus_read(8'h08, r); check("R2 wcmd readback quad", r, 32'h2000_0002);
    bus_write(8'h14, 32'h1234_56EE);
    wait_idle();

    // R2 width code 3 acts as four lines
    bus_write(8'h08, 32'h3000_0000);
    bus_write(8'h14, 32'hB700_0000);
    wait_idle();

    // R6 single-line read of four bytes
    bus_write(8'h0C, 32'h0000_0003);
    bus_read(8'h40, r); check("R4 status while reading", r, 32'h0000_000C);
    wait_idle();
    bus_read(8'h10, r); check("R6 read x1 4 bytes", r, m_rdword);

    // R6 dual-line read of one byte, low bytes zero
    bus_write(8'h0C, 32'h1000_0000);
    wait_idle();
    bus_read(8'h10, r); check("R6 read x2 1 byte", r, m_rdword);
    check("R6 unused bytes zero", r & 32'h00FF_FFFF, 32'h0);

    // R6 quad read of two bytes
    bus_write(8'h0C, 32'h2000_0001);
    wait_idle();
    bus_read(8'h10, r); check("R6 read x4 2 bytes", r, m_rdword);

    // R9 writes while busy are ignored (read in flight)
    bus_write(8'h0C, 32'h0000_0003);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'h0C, 32'h2000_0000);
    wait_idle();
    bus_read(8'h10, r); check("R9 read result unaffected", r, m_rdword);
    bus_read(8'h40, r); check("R9 no burst follows", r, 32'h0);

    // R9 writes while busy are ignored (write in flight)
    bus_write(8'h08, 32'h0000_0001);
    bus_write(8'h14, 32'hA55A_0000);
    bus_write(8'h14, 32'h0F0F_0F0F);
    bus_write(8'h0C, 32'h0000_0000);
    wait_idle();
    bus_read(8'h40, r); check("R9 idle after ignored writes", r, 32'h0);

    // R5 chip-select held across all bursts, then switch and release
    check("R5 cs held", {30'd0, spi_cs_n}, 32'h2);
    bus_write(8'h04, 32'hFFFF_FFEF);
    bus_read(8'h04, r); check("R5 cs readback dev1", r, 32'hFFFF_FFEF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, r); check("R5 cs released", r, 32'hFFFF_FFFF);

    repeat (10) @(posedge clk);
    cmp_on = 1'b0;
    finish_test();
  end

endmodule